// File: doc/BRIEF.md
# Synchronous Late-Write SRAM with Zero Bus Turnaround

This block is a single-port synchronous static memory. Reads and writes may follow each other on the data bus in any order at full clock rate, with no idle cycle when the direction changes. Every control input is sampled on the rising clock edge: address, three chip selects, write strobe, per-byte write enables and a load/advance choice. Write data does not travel with its address. It arrives on a later edge, and a read of a word whose write has not yet landed still returns the new contents.

A static timing input picks one of two read latencies. In flow-through timing the read word appears in the cycle right after the command edge, and write data is taken one edge after its address. In pipelined timing the read word passes through an output register and appears one cycle later, and write data is taken two edges after its address. A two-bit burst counter steps the low address bits in linear or interleaved order. An asynchronous output enable and an asynchronous sleep input gate the read drivers. Sleep also blocks new commands. The array is a parameterized register file that is not cleared by reset.

Top module: `nbt_sram`

## Requirements
- R1: While and after reset (rst_n low), no command is in flight and dq_drive is 0 with dq_out all zero. Memory contents are not changed by reset.
- R2: With adv=0, a command is accepted only when cs0_n=0, cs1=1 and cs2_n=0. Any other combination is a deselect: it does not write and produces no read data. we_n=0 selects a write and we_n=1 selects a read.
- R3: With pipe_mode=0, a read accepted at edge k is shown on dq_out with dq_drive=1 between edges k and k+1. A write accepted at edge k takes its data from din at edge k+1.
- R4: With pipe_mode=1, a read accepted at edge k is shown between edges k+1 and k+2. A write accepted at edge k takes its data from din at edge k+2.
- R5: Reads and writes can be issued back to back in any order with no idle cycle. Every read returns the word as updated by all earlier accepted writes in issue order, including a write whose data is only taken on the same edge that captures the read.
- R6: Bit bw_n[i]=0 writes bits [9i+8:9i] of the word. A byte whose bw_n bit is 1 keeps its old value. The enables are sampled with the address.
- R7: With adv=1 and a live burst, the next word of the burst is accessed with the same read or write type as the command that opened it. Chip selects and we_n are ignored on that edge, and address bits above bit 1 are unchanged. The burst keeps cycling after four words.
- R8: With burst_ilv=0, the n-th word after a start whose low bits are s uses low address bits (s+n) mod 4.
- R9: With burst_ilv=1, the n-th word after a start whose low bits are s uses low address bits s XOR (n mod 4).
- R10: A burst ends on any deselect or sleep edge, and after reset. An adv=1 edge with no live burst is a deselect.
- R11: oe_n=1 forces dq_drive to 0 and dq_out to zero at once, whatever the pipeline holds.
- R12: On an edge with sleep=1 the command is ignored, and dq_drive is 0 while sleep is 1. The memory contents and writes accepted before sleep are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| pipe_mode | input | 1 | 1 = pipelined timing, 0 = flow-through timing; changed only in reset |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear; changed only in reset |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = continue the burst, 0 = load a new command |
| we_n | input | 1 | 0 = write, 1 = read (load cycles only) |
| addr | input | AW | Word address |
| bw_n | input | NB | Byte write enables, active low, one per 9-bit byte |
| din | input | NB*BW | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep: blocks commands and drivers |
| dq_out | output | NB*BW | Read data, zero when not driven |
| dq_drive | output | 1 | High when dq_out carries read data |

## Verification
The hardest case is a read and an earlier write to the same word falling on the same edge. In pipelined timing, the edge that captures the read into the output register is the edge that takes the earlier write's data from din, so the register must take the new bytes from the bus. This is provoked by write-read-write-read runs to one address, by partial byte writes followed at once by a read, and by long random mixes of reads, writes and bursts over a 16-word array in all four timing and burst-order combinations. Every read is judged against a bench memory that applies each write in issue order at the moment the write is issued.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pipe_mode,
  input  logic                 burst_ilv,
  input  logic                 cs0_n,
  input  logic                 cs1,
  input  logic                 cs2_n,
  input  logic                 adv,
  input  logic                 we_n,
  input  logic [AW-1:0]        addr,
  input  logic [NB-1:0]        bw_n,
  input  logic [NB*BW-1:0]     din,
  input  logic                 oe_n,
  input  logic                 sleep,
  output logic [NB*BW-1:0]     dq_out,
  output logic                 dq_drive
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          c1_v, c1_w, c2_v, c2_w, live, rq_v;
  logic [AW-1:0] c1_a, c2_a;
  logic [NB-1:0] c1_be, c2_be;
  logic [1:0]    b_start, b_cnt;
  logic [DW-1:0] rq_d, rd_word;

  wire       sel     = !cs0_n && cs1 && !cs2_n;
  wire       load    = !sleep && !adv && sel;
  wire       step    = !sleep && adv && live;
  wire [1:0] nxt_cnt = b_cnt + 2'd1;
  wire [1:0] nxt_lo  = burst_ilv ? (b_start ^ nxt_cnt) : (b_start + nxt_cnt);

  wire          wr_go = pipe_mode ? (c2_v && c2_w) : (c1_v && c1_w);
  wire [AW-1:0] wr_a  = pipe_mode ? c2_a : c1_a;
  wire [NB-1:0] wr_be = pipe_mode ? c2_be : c1_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_v <= 1'b0; c1_w <= 1'b0; c1_a <= '0; c1_be <= '0;
      c2_v <= 1'b0; c2_w <= 1'b0; c2_a <= '0; c2_be <= '0;
      live <= 1'b0; b_start <= '0; b_cnt <= '0;
      rq_v <= 1'b0; rq_d <= '0;
    end else begin
      c1_v  <= load || step;
      c1_be <= ~bw_n;
      if (load) begin
        c1_w    <= !we_n;
        c1_a    <= addr;
        b_start <= addr[1:0];
        b_cnt   <= 2'd0;
        live    <= 1'b1;
      end else if (step) begin
        c1_a  <= {c1_a[AW-1:2], nxt_lo};
        b_cnt <= nxt_cnt;
      end else begin
        live <= 1'b0;
      end
      c2_v  <= c1_v;
      c2_w  <= c1_w;
      c2_a  <= c1_a;
      c2_be <= c1_be;
      rq_v  <= c1_v && !c1_w;
      rq_d  <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go)
      for (int b = 0; b < NB; b++)
        if (wr_be[b]) mem[wr_a][b*BW +: BW] <= din[b*BW +: BW];
  end

  always_comb begin
    rd_word = mem[c1_a];
    for (int b = 0; b < NB; b++)
      if (wr_go && wr_a == c1_a && wr_be[b]) rd_word[b*BW +: BW] = din[b*BW +: BW];
  end

  assign dq_drive = !oe_n && !sleep && (pipe_mode ? rq_v : (c1_v && !c1_w));
  assign dq_out   = dq_drive ? (pipe_mode ? rq_d : rd_word) : '0;

  assert_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adv && !sel) |=> !c1_v);

  assert_late_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && c1_v && c1_w) |=> (c2_v && c2_w && c2_a == $past(c1_a)));

  assert_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && c1_v && !c1_w && c2_v && c2_w && c2_a == c1_a && (&c2_be))
      |=> (rq_d == $past(din)));

  assert_linear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_ilv && !sleep && adv && live)
      |=> (c1_v && c1_a[1:0] == $past(c1_a[1:0]) + 2'd1 && c1_a[AW-1:2] == $past(c1_a[AW-1:2])));

  assert_no_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !live) |=> !c1_v);

  assert_sleep_block_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !c1_v);
endmodule

// File: tb/tb_nbt_sram.sv
`timescale 1ns/1ps
module tb_nbt_sram;
  localparam int AW = 4, NB = 2, BW = 9, DW = NB * BW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pipe_mode, burst_ilv, cs0_n, cs1, cs2_n, adv, we_n, oe_n, sleep, dq_drive;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] din, dq_out;

  nbt_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv(adv), .we_n(we_n),
    .addr(addr), .bw_n(bw_n), .din(din), .oe_n(oe_n), .sleep(sleep),
    .dq_out(dq_out), .dq_drive(dq_drive));

  int checks = 0, fails = 0, n = 0;
  string tag = "R1";
  logic [DW-1:0] refm [16];
  logic [DW-1:0] wd [4];
  logic [DW-1:0] re [4];
  logic          rf [4];
  logic          m_live, m_typ;
  logic [1:0]    m_st, m_cnt;
  logic [AW-1:0] m_cur;

  task automatic issue(input logic c0n, input logic c1, input logic c2n, input logic av,
                       input logic wn, input logic [AW-1:0] a, input logic [NB-1:0] bn,
                       input logic [DW-1:0] wdat, input logic oe, input logic sl);
    int lat;
    logic ef, ed, ld, stp;
    logic [DW-1:0] ev;
    lat = pipe_mode ? 2 : 1;
    ef = 1'b0; ev = '0;
    if (n >= lat) begin ef = rf[(n-lat)&3]; ev = re[(n-lat)&3]; end
    ed = ef && !oe_n && !sleep;
    checks++;
    if (dq_drive !== ed || dq_out !== (ed ? ev : '0)) begin
      fails++;
      $display("FAIL %s cycle %0d: drive=%b data=%h expected drive=%b data=%h",
               tag, n, dq_drive, dq_out, ed, ed ? ev : '0);
    end
    din = (n >= lat) ? wd[(n-lat)&3] : DW'($urandom);
    cs0_n = c0n; cs1 = c1; cs2_n = c2n; adv = av; we_n = wn; addr = a; bw_n = bn;
    oe_n = oe; sleep = sl;
    ld  = !sl && !av && !c0n && c1 && !c2n;
    stp = !sl && av && m_live;
    rf[n&3] = 1'b0;
    wd[n&3] = DW'($urandom);
    if (ld) begin
      m_live = 1'b1; m_st = a[1:0]; m_cnt = 2'd0; m_cur = a; m_typ = !wn;
    end else if (stp) begin
      m_cnt = m_cnt + 2'd1;
      m_cur = {m_cur[AW-1:2], (burst_ilv ? (m_st ^ m_cnt) : (m_st + m_cnt))};
    end else m_live = 1'b0;
    if (ld || stp) begin
      if (m_typ) begin
        wd[n&3] = wdat;
        for (int b = 0; b < NB; b++)
          if (!bn[b]) refm[m_cur][b*BW +: BW] = wdat[b*BW +: BW];
      end else begin
        rf[n&3] = 1'b1;
        re[n&3] = refm[m_cur];
      end
    end
    @(posedge clk); @(negedge clk);
    n++;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bn, input logic [DW-1:0] d);
    issue(0, 1, 0, 0, 0, a, bn, d, 0, 0);
  endtask
  task automatic rd(input logic [AW-1:0] a);
    issue(0, 1, 0, 0, 1, a, '1, '0, 0, 0);
  endtask
  task automatic idle();
    issue(1, 0, 1, 0, 1, '0, '1, '0, 0, 0);
  endtask

  task automatic do_reset(input logic pm, input logic ilv);
    for (int i = 0; i < 3; i++) idle();
    rst_n = 1'b0; pipe_mode = pm; burst_ilv = ilv;
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (dq_drive !== 1'b0 || dq_out !== '0) begin
      fails++;
      $display("FAIL R1 in reset: drive=%b data=%h expected drive=0 data=0", dq_drive, dq_out);
    end
    rst_n = 1'b1;
    n = 0; m_live = 1'b0;
    for (int i = 0; i < 4; i++) rf[i] = 1'b0;
    idle();
  endtask

  task automatic config_run(input logic pm, input logic ilv);
    do_reset(pm, ilv);
    tag = "R2";
    for (int k = 0; k < 8; k++) issue(k[0], k[1], k[2], 0, 0, 4'd3, '0, DW'(18'h100 + k), 0, 0);
    for (int k = 0; k < 8; k++) issue(k[0], k[1], k[2], 0, 1, 4'd3, '1, '0, 0, 0);
    tag = "R5";
    wr(5, '0, 18'h2A5A5); rd(5); wr(5, '0, 18'h15A5A); rd(5); rd(5); wr(6, '0, 18'h3FFFF); rd(6); wr(5, '0, 18'h00001); rd(5);
    tag = "R6";
    wr(9, '0, 18'h0F0F0); wr(9, 2'b10, 18'h3C1AB); rd(9); wr(9, 2'b01, 18'h2AD55); rd(9); wr(9, 2'b11, 18'h3FFFF); rd(9);
    tag = ilv ? "R9" : "R8";
    issue(0, 1, 0, 0, 0, 4'd6, '0, 18'h11111, 0, 0);
    for (int i = 0; i < 5; i++) issue(1, 0, 1, 1, 1, 4'd0, '0, DW'(18'h22220 + i), 0, 0);
    issue(0, 1, 0, 0, 1, 4'd5, '1, '0, 0, 0);
    for (int i = 0; i < 6; i++) issue(1, 0, 1, 1, 0, 4'd0, '1, '0, 0, 0);
    tag = "R7";
    issue(0, 1, 0, 0, 0, 4'd13, 2'b01, 18'h3A5C3, 0, 0);
    issue(0, 1, 0, 1, 1, 4'd2, 2'b10, 18'h0C35A, 0, 0);
    issue(0, 1, 0, 0, 1, 4'd12, '1, '0, 0, 0);
    for (int i = 0; i < 3; i++) issue(0, 1, 0, 1, 0, 4'd0, '0, 18'h3FFFF, 0, 0);
    tag = "R10";
    idle(); issue(0, 1, 0, 1, 1, 4'd5, '1, '0, 0, 0); issue(0, 1, 0, 1, 0, 4'd5, '0, 18'h00BAD, 0, 0); rd(5);
    tag = "R11";
    issue(0, 1, 0, 0, 1, 4'd5, '1, '0, 1, 0); issue(0, 1, 0, 0, 1, 4'd6, '1, '0, 1, 0);
    issue(0, 1, 0, 0, 1, 4'd9, '1, '0, 1, 0); rd(3); rd(5);
    tag = "R12";
    wr(7, '0, 18'h1D1D1); rd(7);
    issue(0, 1, 0, 0, 0, 4'd7, '0, 18'h0DEAD, 0, 1);
    issue(0, 1, 0, 0, 1, 4'd7, '1, '0, 0, 1);
    issue(0, 1, 0, 1, 1, 4'd7, '1, '0, 0, 1);
    rd(7); rd(9); rd(7);
    tag = pm ? "R4" : "R3";
    for (int i = 0; i < 600; i++) begin
      logic dsel, av, slp, oe;
      logic [2:0] cs;
      dsel = ($urandom % 8) == 0;
      cs   = dsel ? 3'($urandom) : 3'b010;
      av   = ($urandom % 3) == 0;
      slp  = ($urandom % 20) == 0;
      oe   = ($urandom % 10) == 0;
      issue(cs[0], cs[1], cs[2], av, 1'($urandom), AW'($urandom), NB'($urandom), DW'($urandom), oe, slp);
    end
    tag = "R5";
    for (int a = 0; a < 16; a++) rd(AW'(a));
  endtask

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0; burst_ilv = 1'b0;
    cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1; adv = 1'b0; we_n = 1'b1;
    addr = '0; bw_n = '1; din = '0; oe_n = 1'b0; sleep = 1'b0;
    m_live = 1'b0; m_typ = 1'b0; m_st = '0; m_cnt = '0; m_cur = '0;
    for (int i = 0; i < 4; i++) begin rf[i] = 1'b0; wd[i] = '0; re[i] = '0; end
    for (int i = 0; i < 16; i++) refm[i] = '0;
    @(negedge clk);
    do_reset(0, 0);
    tag = "R3";
    for (int a = 0; a < 16; a++) wr(AW'(a), '0, DW'(a * 4099));
    for (int a = 0; a < 16; a++) rd(AW'(a));
    config_run(0, 0);
    config_run(0, 1);
    config_run(1, 0);
    config_run(1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule